// File: doc/BRIEF.md
# Thermal Count Converter

This block turns a raw count from an on-die temperature sensor into a signed temperature in millidegrees Celsius. It also runs the same linear relation backwards: a temperature threshold becomes the raw count that would produce it, so trip limits can be compared directly against sensor counts. The relation uses a signed slope that is scaled down by 2^14, an offset, and a golden reference temperature in whole degrees. The golden temperature is weighted by 500 and added to the offset.

The two directions are independent channels, and each has a valid/ready request side and a valid/ready result side. The forward channel is a short multiply-and-add pipeline. The inverse channel needs a signed divide, which a one-bit-per-cycle restoring divider performs. A sensor count whose significant field is zero is reported as an invalid reading and is not converted. One threshold value, -274000 mC, is reserved to mean "reboot threshold disabled", and it passes through without a divide.

The coefficients sit in a small register set. Writes to it are accepted only while both channels are quiet, so a conversion in progress never sees its coefficients change partway through.

Top module: `thermo_conv`

## Requirements
- R1: After reset both request sides are ready, neither result side is valid, and the coefficients are slope -250460, offset 250460 and golden 50.
- R2: A forward result equals floor(slope × count / 2^14) + golden × 500 + offset. The product is formed at 64 bits and the result is the signed low 32 bits.
- R3: Only the low 24 bits of the 32-bit count input take part in the conversion. Bits 31..24 have no effect on the result.
- R4: When the low 24 bits of the count are all zero, the forward result has its invalid flag set to 1 and its temperature set to 0. A nonzero count gives an invalid flag of 0.
- R5: An inverse result equals the low 32 bits of ((golden × 500 + offset − threshold) × 2^14) / (−slope). The divide is signed and truncates toward zero.
- R6: A threshold of exactly -274000 gives a result with the disabled flag at 1 and a raw value of 0, valid on the first clock edge after acceptance. Any other threshold gives a disabled flag of 0.
- R7: Each request side drops ready on the edge that accepts a request. It stays low until that channel's result has been taken, so the inverse side is held off for the whole divide.
- R8: While a result is valid and not taken, the result stays valid and its data fields do not change.
- R9: A coefficient write is ignored in any cycle in which either channel holds a request, has a result waiting, or is presenting a new request. A write in a cycle when both channels are quiet takes effect for the following conversions.
- R10: The forward and inverse channels can accept requests on the same edge and run concurrently. Neither result is affected by the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Coefficient write strobe |
| cfg_slope | input | 32 | Signed slope, applied with a 2^-14 scale |
| cfg_offset | input | 32 | Signed offset in mC |
| cfg_golden | input | 8 | Golden reference temperature in degrees |
| fwd_in_valid | input | 1 | Count request valid |
| fwd_in_ready | output | 1 | Forward channel can accept a count |
| fwd_in_raw | input | 32 | Raw sensor count (low 24 bits significant) |
| fwd_out_valid | output | 1 | Temperature result valid |
| fwd_out_ready | input | 1 | Temperature result taken |
| fwd_out_temp | output | 32 | Signed temperature in mC |
| fwd_out_invalid | output | 1 | Count was zero, no temperature |
| thr_in_valid | input | 1 | Threshold request valid |
| thr_in_ready | output | 1 | Inverse channel can accept a threshold |
| thr_in_temp | input | 32 | Signed threshold in mC |
| thr_out_valid | output | 1 | Raw-count result valid |
| thr_out_ready | input | 1 | Raw-count result taken |
| thr_out_raw | output | 32 | Raw count for the threshold |
| thr_out_disabled | output | 1 | Threshold was the disable code |

## Verification
The two channels can accept a request on the same clock edge. The bench provokes this by starting a count and a threshold from the same falling edge, and it judges each result on its own against the model value. The lock on coefficient writes can also land while the divider is busy. The bench issues a write in the middle of a divide, then runs conversions that must still use the old coefficients. After that it repeats the write while both channels are quiet and checks that the new coefficients are used.

// File: rtl/thermo_conv_pkg.sv
package thermo_conv_pkg;

  localparam int unsigned GOLD_SCALE    = 500;
  localparam int          RESET_SLOPE   = -250460;
  localparam int          RESET_OFFSET  = 250460;
  localparam int          RESET_GOLDEN  = 50;
  localparam int          TRIP_OFF_CODE = -274000;

  typedef enum logic [1:0] {F_IDLE, F_MUL, F_ADD, F_OUT} fwd_st_e;
  typedef enum logic [1:0] {V_IDLE, V_DIV, V_FIX, V_OUT} inv_st_e;

endpackage

// File: rtl/thermo_conv_coef.sv
module thermo_conv_coef
  import thermo_conv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GOLD_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_req,
  input  logic                     paths_idle,
  input  logic signed [DATA_W-1:0] slope_in,
  input  logic signed [DATA_W-1:0] offset_in,
  input  logic        [GOLD_W-1:0] golden_in,
  output logic signed [DATA_W-1:0] slope,
  output logic signed [DATA_W-1:0] base
);

  // golden*500 folded into the offset once, at write time
  logic signed [DATA_W-1:0] gold_term;
  assign gold_term = $signed(DATA_W'(golden_in) * DATA_W'(GOLD_SCALE));

  always_ff @(posedge clk) begin
    if (rst) begin
      slope <= DATA_W'(RESET_SLOPE);
      base  <= DATA_W'(RESET_GOLDEN * GOLD_SCALE + RESET_OFFSET);
    end else if (wr_req && paths_idle) begin
      slope <= slope_in;
      base  <= gold_term + offset_in;
    end
  end

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !paths_idle) |=> ($stable(slope) && $stable(base)));

endmodule

// File: rtl/thermo_conv_fwd.sv
module thermo_conv_fwd
  import thermo_conv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IN_W   = 32,
  parameter int RAW_W  = 24,
  parameter int FRAC_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] slope,
  input  logic signed [DATA_W-1:0] base,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic        [IN_W-1:0]   in_raw,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_temp,
  output logic                     out_invalid,
  output logic                     idle
);

  localparam int PROD_W = 2 * DATA_W;

  fwd_st_e                   st;
  logic [RAW_W-1:0]          raw_q;
  logic                      zero_q;
  logic signed [PROD_W-1:0]  prod_q;
  logic [RAW_W-1:0]          raw_m;
  logic                      unused_hi;
  logic signed [PROD_W-1:0]  slope_x, raw_x, sum_x;

  assign raw_m     = in_raw[RAW_W-1:0];
  assign unused_hi = ^in_raw[IN_W-1:RAW_W];
  assign slope_x   = $signed({{DATA_W{slope[DATA_W-1]}}, slope});
  assign raw_x     = $signed({{(PROD_W-RAW_W){1'b0}}, raw_q});
  assign sum_x     = (prod_q >>> FRAC_W) + $signed({{DATA_W{base[DATA_W-1]}}, base});

  assign in_ready = (st == F_IDLE);
  assign idle     = (st == F_IDLE) && !in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= F_IDLE;
      raw_q       <= '0;
      zero_q      <= 1'b0;
      prod_q      <= '0;
      out_valid   <= 1'b0;
      out_temp    <= '0;
      out_invalid <= 1'b0;
    end else begin
      case (st)
        F_IDLE: if (in_valid) begin
          raw_q  <= raw_m;
          zero_q <= (raw_m == '0);
          st     <= F_MUL;
        end
        F_MUL: begin
          prod_q <= slope_x * raw_x;
          st     <= F_ADD;
        end
        F_ADD: begin
          out_valid   <= 1'b1;
          out_invalid <= zero_q;
          out_temp    <= zero_q ? '0 : sum_x[DATA_W-1:0];
          st          <= F_OUT;
        end
        default: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= F_IDLE;
        end
      endcase
    end
  end

  p_temp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_temp) && $stable(out_invalid)));

  p_zero_no_temp_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_temp == '0));

  p_fwd_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/thermo_conv_inv.sv
module thermo_conv_inv
  import thermo_conv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] slope,
  input  logic signed [DATA_W-1:0] base,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_temp,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic        [DATA_W-1:0] out_raw,
  output logic                     out_disabled,
  output logic                     idle
);

  localparam int NUM_W = DATA_W + FRAC_W + 2;
  localparam int DEN_W = DATA_W + 1;
  localparam int REM_W = DEN_W + 1;
  localparam int CNT_W = $clog2(NUM_W + 1);

  inv_st_e                  st;
  logic [NUM_W-1:0]         quo;
  logic [REM_W-1:0]         rem;
  logic [DEN_W-1:0]         dmag;
  logic                     neg_q;
  logic [CNT_W-1:0]         cnt;

  logic signed [DATA_W:0]   diff;
  logic signed [NUM_W-1:0]  num;
  logic signed [DEN_W-1:0]  den;
  logic [REM_W-1:0]         rem_sh;
  logic [NUM_W-1:0]         quo_neg;
  logic                     is_off;

  assign is_off  = (in_temp == DATA_W'(TRIP_OFF_CODE));
  assign diff    = $signed({base[DATA_W-1], base}) - $signed({in_temp[DATA_W-1], in_temp});
  assign num     = $signed({{(NUM_W-DATA_W-1){diff[DATA_W]}}, diff}) <<< FRAC_W;
  assign den     = -$signed({slope[DATA_W-1], slope});
  assign rem_sh  = {rem[REM_W-2:0], quo[NUM_W-1]};
  assign quo_neg = -quo;

  assign in_ready = (st == V_IDLE);
  assign idle     = (st == V_IDLE) && !in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= V_IDLE;
      quo          <= '0;
      rem          <= '0;
      dmag         <= '0;
      neg_q        <= 1'b0;
      cnt          <= '0;
      out_valid    <= 1'b0;
      out_raw      <= '0;
      out_disabled <= 1'b0;
    end else begin
      case (st)
        V_IDLE: if (in_valid) begin
          if (is_off) begin
            out_valid    <= 1'b1;
            out_disabled <= 1'b1;
            out_raw      <= '0;
            st           <= V_OUT;
          end else begin
            quo   <= num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
            dmag  <= den[DEN_W-1] ? DEN_W'(-den) : DEN_W'(den);
            neg_q <= num[NUM_W-1] ^ den[DEN_W-1];
            rem   <= '0;
            cnt   <= CNT_W'(NUM_W);
            st    <= V_DIV;
          end
        end
        V_DIV: begin
          if (rem_sh >= REM_W'(dmag)) begin
            rem <= rem_sh - REM_W'(dmag);
            quo <= {quo[NUM_W-2:0], 1'b1};
          end else begin
            rem <= rem_sh;
            quo <= {quo[NUM_W-2:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= V_FIX;
        end
        V_FIX: begin
          out_raw      <= neg_q ? quo_neg[DATA_W-1:0] : quo[DATA_W-1:0];
          out_disabled <= 1'b0;
          out_valid    <= 1'b1;
          st           <= V_OUT;
        end
        default: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= V_IDLE;
        end
      endcase
    end
  end

  p_raw_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_raw) && $stable(out_disabled)));

  p_trip_off_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_temp == DATA_W'(TRIP_OFF_CODE))
      |=> (out_valid && out_disabled && out_raw == '0));

  p_inv_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/thermo_conv.sv
module thermo_conv
  import thermo_conv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IN_W   = 32,
  parameter int RAW_W  = 24,
  parameter int FRAC_W = 14,
  parameter int GOLD_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  logic signed [DATA_W-1:0] cfg_slope,
  input  logic signed [DATA_W-1:0] cfg_offset,
  input  logic        [GOLD_W-1:0] cfg_golden,
  input  logic                     fwd_in_valid,
  output logic                     fwd_in_ready,
  input  logic        [IN_W-1:0]   fwd_in_raw,
  output logic                     fwd_out_valid,
  input  logic                     fwd_out_ready,
  output logic signed [DATA_W-1:0] fwd_out_temp,
  output logic                     fwd_out_invalid,
  input  logic                     thr_in_valid,
  output logic                     thr_in_ready,
  input  logic signed [DATA_W-1:0] thr_in_temp,
  output logic                     thr_out_valid,
  input  logic                     thr_out_ready,
  output logic        [DATA_W-1:0] thr_out_raw,
  output logic                     thr_out_disabled
);

  logic signed [DATA_W-1:0] slope, base;
  logic                     fwd_idle, inv_idle;

  thermo_conv_coef #(.DATA_W(DATA_W), .GOLD_W(GOLD_W)) u_coef (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (cfg_wr),
    .paths_idle (fwd_idle && inv_idle),
    .slope_in   (cfg_slope),
    .offset_in  (cfg_offset),
    .golden_in  (cfg_golden),
    .slope      (slope),
    .base       (base)
  );

  thermo_conv_fwd #(.DATA_W(DATA_W), .IN_W(IN_W), .RAW_W(RAW_W), .FRAC_W(FRAC_W)) u_fwd (
    .clk         (clk),
    .rst         (rst),
    .slope       (slope),
    .base        (base),
    .in_valid    (fwd_in_valid),
    .in_ready    (fwd_in_ready),
    .in_raw      (fwd_in_raw),
    .out_valid   (fwd_out_valid),
    .out_ready   (fwd_out_ready),
    .out_temp    (fwd_out_temp),
    .out_invalid (fwd_out_invalid),
    .idle        (fwd_idle)
  );

  thermo_conv_inv #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_inv (
    .clk          (clk),
    .rst          (rst),
    .slope        (slope),
    .base         (base),
    .in_valid     (thr_in_valid),
    .in_ready     (thr_in_ready),
    .in_temp      (thr_in_temp),
    .out_valid    (thr_out_valid),
    .out_ready    (thr_out_ready),
    .out_raw      (thr_out_raw),
    .out_disabled (thr_out_disabled),
    .idle         (inv_idle)
  );

endmodule

// File: tb/thermo_conv_tb.sv
module thermo_conv_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst;
  logic               cfg_wr;
  logic signed [31:0] cfg_slope, cfg_offset;
  logic [7:0]         cfg_golden;
  logic               fwd_in_valid, fwd_in_ready, fwd_out_valid, fwd_out_ready, fwd_out_invalid;
  logic [31:0]        fwd_in_raw;
  logic signed [31:0] fwd_out_temp;
  logic               thr_in_valid, thr_in_ready, thr_out_valid, thr_out_ready, thr_out_disabled;
  logic signed [31:0] thr_in_temp;
  logic [31:0]        thr_out_raw;

  int checks = 0;
  int fails  = 0;
  int ma = -250460, mb = 250460, mg = 50;

  thermo_conv u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] exp_fwd(input int a, input int b, input int g, input logic [31:0] raw);
    longint r = longint'(raw & 32'h00FF_FFFF);
    longint p = longint'(a) * r;
    longint t = (p >>> 14) + longint'(g) * 500 + longint'(b);
    return t[31:0];
  endfunction

  function automatic logic [31:0] exp_inv(input int a, input int b, input int g, input int t);
    longint n = (longint'(g) * 500 + longint'(b) - longint'(t)) <<< 14;
    longint q = n / (-longint'(a));
    return q[31:0];
  endfunction

  task automatic write_cfg(input int a, input int b, input int g);
    cfg_slope = a; cfg_offset = b; cfg_golden = g[7:0]; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_fwd(input logic [31:0] raw, input int stall,
                         output logic signed [31:0] t, output logic bad);
    fwd_in_raw = raw; fwd_in_valid = 1'b1;
    while (!fwd_in_ready) @(negedge clk);
    @(negedge clk);
    fwd_in_valid = 1'b0;
    chk(fwd_in_ready == 1'b0, "R7 fwd ready after accept", fwd_in_ready, 0);
    while (!fwd_out_valid) @(negedge clk);
    t = fwd_out_temp; bad = fwd_out_invalid;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(fwd_out_valid && fwd_out_temp == t && fwd_out_invalid == bad,
          "R8 fwd hold", fwd_out_temp, t);
    end
    fwd_out_ready = 1'b1;
    @(negedge clk);
    fwd_out_ready = 1'b0;
  endtask

  task automatic run_inv(input int temp, input int stall,
                         output logic [31:0] r, output logic dis, output int lat);
    thr_in_temp = temp; thr_in_valid = 1'b1;
    while (!thr_in_ready) @(negedge clk);
    @(negedge clk);
    thr_in_valid = 1'b0;
    chk(thr_in_ready == 1'b0, "R7 thr ready after accept", thr_in_ready, 0);
    lat = 0;
    while (!thr_out_valid) begin
      @(negedge clk);
      lat++;
      if (!thr_out_valid)
        chk(thr_in_ready == 1'b0, "R7 thr ready during divide", thr_in_ready, 0);
    end
    r = thr_out_raw; dis = thr_out_disabled;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(thr_out_valid && thr_out_raw == r && thr_out_disabled == dis,
          "R8 thr hold", thr_out_raw, r);
    end
    thr_out_ready = 1'b1;
    @(negedge clk);
    thr_out_ready = 1'b0;
  endtask

  task automatic fwd_case(input logic [31:0] raw, input int stall, input string req);
    logic signed [31:0] t; logic bad;
    logic zero_in = ((raw & 32'h00FF_FFFF) == 0);
    run_fwd(raw, stall, t, bad);
    chk(bad == zero_in, {req, " invalid flag"}, bad, zero_in);
    chk(t == (zero_in ? 32'sd0 : exp_fwd(ma, mb, mg, raw)), {req, " temp"}, t,
        zero_in ? 0 : exp_fwd(ma, mb, mg, raw));
  endtask

  task automatic inv_case(input int temp, input int stall, input string req);
    logic [31:0] r; logic dis; int lat;
    run_inv(temp, stall, r, dis, lat);
    if (temp == -274000) begin
      chk(dis == 1'b1 && r == 0, {req, " disable code"}, r, 0);
      chk(lat == 0, {req, " disable latency"}, lat, 0);
    end else begin
      chk(dis == 1'b0, {req, " disabled flag"}, dis, 0);
      chk(r == exp_inv(ma, mb, mg, temp), {req, " raw"}, r, exp_inv(ma, mb, mg, temp));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd9137));
    rst = 1'b1; cfg_wr = 1'b0; cfg_slope = '0; cfg_offset = '0; cfg_golden = '0;
    fwd_in_valid = 1'b0; fwd_in_raw = '0; fwd_out_ready = 1'b0;
    thr_in_valid = 1'b0; thr_in_temp = '0; thr_out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state and default coefficients
    chk(fwd_in_ready && thr_in_ready, "R1 ready after reset", {fwd_in_ready, thr_in_ready}, 3);
    chk(!fwd_out_valid && !thr_out_valid, "R1 no result after reset",
        {fwd_out_valid, thr_out_valid}, 0);
    fwd_case(32'h0000_4650, 0, "R1 default coef");
    inv_case(85000, 0, "R1 default coef inverse");

    // R2 forward corners
    fwd_case(32'h0000_0001, 0, "R2 count one");
    fwd_case(32'h00FF_FFFF, 0, "R2 count max");
    // R3 masking of upper bits
    begin
      logic signed [31:0] t1, t2; logic b1, b2;
      run_fwd(32'hAB00_1234, 0, t1, b1);
      run_fwd(32'h0000_1234, 0, t2, b2);
      chk(t1 == t2 && b1 == b2, "R3 upper bits ignored", t1, t2);
      chk(t1 == exp_fwd(ma, mb, mg, 32'h1234), "R3 masked value", t1, exp_fwd(ma, mb, mg, 32'h1234));
    end
    // R4 zero after masking
    fwd_case(32'hFF00_0000, 0, "R4 masked zero");
    fwd_case(32'h0000_0000, 0, "R4 zero");
    // R5 inverse corners, including a negative quotient
    inv_case(400000, 0, "R5 negative quotient");
    inv_case(-40000, 0, "R5 cold threshold");
    // R6 disable code and its neighbour
    inv_case(-274000, 0, "R6");
    inv_case(-273999, 0, "R6 neighbour");
    // R8 stalled results
    fwd_case(32'h0000_5000, 3, "R8 fwd stall");
    inv_case(117000, 3, "R8 thr stall");

    // R10 both channels accepted on the same edge
    fork
      fwd_case(32'h0000_3A98, 0, "R10 concurrent fwd");
      inv_case(105000, 1, "R10 concurrent thr");
    join

    // R9 write during a divide is ignored
    fork
      inv_case(90000, 0, "R9 divide during write");
      begin
        repeat (5) @(negedge clk);
        write_cfg(-200000, 100000, 30);
      end
    join
    fwd_case(32'h0000_4000, 0, "R9 old coef kept");
    inv_case(60000, 0, "R9 old coef kept inverse");
    write_cfg(-200000, 100000, 30);
    ma = -200000; mb = 100000; mg = 30;
    fwd_case(32'h0000_4000, 0, "R9 new coef applied");

    // R2 R5 random coefficients and inputs
    for (int s = 0; s < 5; s++) begin
      ma = -int'($urandom_range(300000, 150000));
      mb = int'($urandom_range(300000, 180000));
      mg = int'($urandom_range(90, 20));
      write_cfg(ma, mb, mg);
      for (int k = 0; k < 8; k++) fwd_case($urandom, k % 2, "R2 random");
      for (int k = 0; k < 4; k++)
        inv_case(int'($urandom_range(200000, 0)) - 60000, 0, "R5 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule